// File: doc/BRIEF.md
# DMA Channel Transfer Controller

This block is the control and status core of a single DMA channel. Software loads a unit count, chooses how units are requested, and enables the channel. A shared master enable must also be set. The block then asks a separate datapath for transfer units, one at a time. It counts down each unit the datapath reports as finished. It stops when the count runs out, when software withdraws either enable, or when an NMI or an address error is reported.

A completion flag is raised only when the count runs out. While that flag is set, the channel cannot run again. The NMI flag and the address-error flag are sticky and also hold the channel stopped. Software clears each of these flags in two steps: it must first read the flag as 1, then write 0 to it. Units can be requested continuously (auto mode), or one per pulse on an external request line or on a peripheral request line.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the channel enable, master enable, mode, count, all three flags, `xfer_active` and `unit_req` are 0. The register map is as follows:
  - Select 0 is control: bit 0 is the channel enable, bit 1 is the completion flag, and bits 3:2 are the request mode.
  - Select 1 is the unit count.
  - Select 2 is global: bit 0 is the master enable, bit 1 is the NMI flag, and bit 2 is the address-error flag.
  - Reads are combinational while `reg_rd` is high.
- R2: `xfer_active` rises on the clock edge after the channel enable, the master enable and "all three flags clear" first hold together. It is never 1 unless all of these conditions hold.
- R3: Each unit is accepted in a cycle where `unit_req` and `unit_done` are both 1 and no stop condition is present. Each accepted unit lowers the count by one. A count loaded as 0 gives 2^CNT_W units.
- R4: The accepted unit that takes the count from 1 to 0 sets the completion flag. On the same edge, `xfer_active` and `unit_req` fall.
- R5: A flag is cleared only by writing 0 to its bit after a read has returned that bit as 1. A write of 0 without such a read, or a write of 1, leaves the flag unchanged.
- R6: While the completion flag is 1, writing the channel enable to 1 starts no transfer.
- R7: A write of 0 to the channel enable or to the master enable drops `xfer_active` on that write's edge. The completion flag is not set, and the count is frozen.
- R8: An `nmi_evt` or `aerr_evt` pulse sets its sticky flag and drops `xfer_active` on the same edge. A unit finishing in that cycle is not counted, and the completion flag stays 0.
- R9: Mode 00 requests units continuously. Mode 01 and mode 11 raise `unit_req` for one unit on the edge after each `ext_req` pulse. Mode 10 does the same for each `per_req` pulse. The request line of the other mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data |
| ext_req | input | 1 | External unit request |
| per_req | input | 1 | Peripheral unit request |
| nmi_evt | input | 1 | NMI event pulse |
| aerr_evt | input | 1 | Address-error event pulse |
| unit_done | input | 1 | Datapath finished a unit |
| xfer_active | output | 1 | Channel is transferring |
| unit_req | output | 1 | Unit request to datapath |

## Verification
A corrupted count shows up within one run as the wrong number of units before `xfer_active` falls. A flag that sets or clears wrongly shows up within a cycle or two: a restart that should be blocked is not, or `xfer_active` fails to come back after a legal clear. A unit that is counted when it should not be appears as a wrong readback of the count straight after the stop. A lost or duplicated request in the request-driven modes changes the number of `unit_req` pulses seen for a given number of request pulses.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO    = 2'b00,
    MODE_EXT     = 2'b01,
    MODE_PERIPH  = 2'b10,
    MODE_EXT_ALT = 2'b11
  } req_mode_e;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_GLOBAL = 2'd2;

  localparam int NUM_FLAGS = 3;
  localparam int FL_END    = 0;
  localparam int FL_NMI    = 1;
  localparam int FL_AERR   = 2;
endpackage

// File: rtl/dmacc_rc_flag.sv
// Sticky flag; cleared by writing 0 only after it was read as 1.
module dmacc_rc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic seen_q, seen_d;

  always_comb begin
    flag_d = flag_q;
    seen_d = seen_q;
    if (rd_i && flag_q) seen_d = 1'b1;
    if (wr_i && !wbit_i && seen_q) begin
      flag_d = 1'b0;
      seen_d = 1'b0;
    end
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dmacc_counter.sv
// Unit down-counter; a loaded zero wraps to all ones on the first unit.
module dmacc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q, count_d;
  logic             dec_en;

  assign dec_en = dec_i && !load_i;
  assign last_o = dec_en && (count_q == ONE);

  always_comb begin
    count_d = count_q;
    if (load_i)      count_d = load_val_i;
    else if (dec_en) count_d = count_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/dmacc_sequencer.sv
// Active state and per-unit request generation.
module dmacc_sequencer
  import dmacc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      permit_i,
  input  logic      kill_i,
  input  logic      last_i,
  input  req_mode_e mode_i,
  input  logic      ext_req_i,
  input  logic      per_req_i,
  input  logic      unit_done_i,
  output logic      active_o,
  output logic      unit_req_o,
  output logic      accept_o
);
  logic active_q, active_d;
  logic pend_q, pend_d;
  logic is_auto, src_req;

  assign is_auto = (mode_i == MODE_AUTO);
  assign src_req = (mode_i == MODE_PERIPH) ? per_req_i : ext_req_i;

  assign unit_req_o = active_q && (is_auto || pend_q);
  assign accept_o   = unit_req_o && unit_done_i && !kill_i;

  always_comb begin
    active_d = permit_i && !kill_i && !last_i;
    pend_d   = pend_q;
    if (accept_o) pend_d = 1'b0;
    if (active_q && !is_auto && src_req) pend_d = 1'b1;
    if (!active_d) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmacc_pkg::*;
#(
  parameter  int CNT_W = 16,
  localparam int REG_W = (CNT_W > 4) ? CNT_W : 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ext_req,
  input  logic             per_req,
  input  logic             nmi_evt,
  input  logic             aerr_evt,
  input  logic             unit_done,
  output logic             xfer_active,
  output logic             unit_req
);
  logic             chan_en_q, chan_en_d;
  logic             master_en_q, master_en_d;
  req_mode_e        mode_q, mode_d;
  logic             wr_ctrl, wr_count, wr_glob, rd_ctrl, rd_glob;
  logic             kill, permit, accept, last_unit;
  logic [CNT_W-1:0] count;
  logic [NUM_FLAGS-1:0] flag_v, set_v, rd_v, wr_v, wbit_v;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_count = reg_wr && (reg_sel == SEL_COUNT);
  assign wr_glob  = reg_wr && (reg_sel == SEL_GLOBAL);
  assign rd_ctrl  = reg_rd && (reg_sel == SEL_CTRL);
  assign rd_glob  = reg_rd && (reg_sel == SEL_GLOBAL);

  always_comb begin
    chan_en_d   = chan_en_q;
    mode_d      = mode_q;
    master_en_d = master_en_q;
    if (wr_ctrl) begin
      chan_en_d = reg_wdata[0];
      mode_d    = req_mode_e'(reg_wdata[3:2]);
    end
    if (wr_glob) master_en_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en_q   <= 1'b0;
      master_en_q <= 1'b0;
      mode_q      <= MODE_AUTO;
    end else begin
      chan_en_q   <= chan_en_d;
      master_en_q <= master_en_d;
      mode_q      <= mode_d;
    end
  end

  assign kill   = nmi_evt || aerr_evt
               || (wr_ctrl && !reg_wdata[0])
               || (wr_glob && !reg_wdata[0]);
  assign permit = chan_en_q && master_en_q && !(|flag_v);

  assign set_v  = {aerr_evt, nmi_evt, last_unit};
  assign rd_v   = {rd_glob, rd_glob, rd_ctrl};
  assign wr_v   = {wr_glob, wr_glob, wr_ctrl};
  assign wbit_v = {reg_wdata[2], reg_wdata[1], reg_wdata[1]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    dmacc_rc_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[g]),
      .rd_i   (rd_v[g]),
      .wr_i   (wr_v[g]),
      .wbit_i (wbit_v[g]),
      .flag_o (flag_v[g])
    );
  end

  dmacc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_count),
    .load_val_i (reg_wdata[CNT_W-1:0]),
    .dec_i      (accept),
    .count_o    (count),
    .last_o     (last_unit)
  );

  dmacc_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .permit_i    (permit),
    .kill_i      (kill),
    .last_i      (last_unit),
    .mode_i      (mode_q),
    .ext_req_i   (ext_req),
    .per_req_i   (per_req),
    .unit_done_i (unit_done),
    .active_o    (xfer_active),
    .unit_req_o  (unit_req),
    .accept_o    (accept)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_sel)
        SEL_CTRL:   reg_rdata = REG_W'({mode_q, flag_v[FL_END], chan_en_q});
        SEL_COUNT:  reg_rdata = REG_W'(count);
        SEL_GLOBAL: reg_rdata = REG_W'({flag_v[FL_AERR], flag_v[FL_NMI], master_en_q});
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic [1:0]       wbits,
  input logic             nmi_evt,
  input logic             aerr_evt,
  input logic             unit_done,
  input logic             xfer_active,
  input logic             unit_req,
  input logic             chan_en,
  input logic             master_en,
  input logic [2:0]       flags,
  input logic [CNT_W-1:0] count
);
  logic stop_wr;
  assign stop_wr = reg_wr && (reg_sel == 2'd0 || reg_sel == 2'd2) && !wbits[0];

  p_active_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (chan_en && master_en && flags == 3'b000));

  p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_req && unit_done && !nmi_evt && !aerr_evt && !stop_wr
     && !(reg_wr && reg_sel == 2'd1))
    |=> count == $past(count) - 1'b1);

  p_end_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> (count == '0 && !xfer_active && !unit_req));

  p_end_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(reg_wr && reg_sel == 2'd0 && !wbits[1])) |=> flags[0]);

  p_event_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt || aerr_evt) |=> (!xfer_active && !unit_req));

  p_flag_no_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags[1] || flags[2]) && !(reg_wr && reg_sel == 2'd1)) |=> $stable(count));

  p_req_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_req |-> xfer_active);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .wbits       (reg_wdata[1:0]),
  .nmi_evt     (nmi_evt),
  .aerr_evt    (aerr_evt),
  .unit_done   (unit_done),
  .xfer_active (xfer_active),
  .unit_req    (unit_req),
  .chan_en     (chan_en_q),
  .master_en   (master_en_q),
  .flags       (flag_v),
  .count       (count)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
  localparam int CNT_W = 4;
  localparam int REG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       reg_sel = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             ext_req = 1'b0;
  logic             per_req = 1'b0;
  logic             nmi_evt = 1'b0;
  logic             aerr_evt = 1'b0;
  logic             unit_done = 1'b0;
  logic             xfer_active;
  logic             unit_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_req(ext_req), .per_req(per_req), .nmi_evt(nmi_evt),
    .aerr_evt(aerr_evt), .unit_done(unit_done),
    .xfer_active(xfer_active), .unit_req(unit_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Both tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] s, input logic [REG_W-1:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int d);
    reg_rd = 1'b1; reg_sel = s;
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_units(input int cycles, output int units);
    units = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (unit_req && unit_done) units++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int v, u, blocked;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl after reset", v, 0);
    rd(1, v); chk("R1 count after reset", v, 0);
    rd(2, v); chk("R1 global after reset", v, 0);
    chk("R1 active after reset", int'(xfer_active), 0);
    chk("R1 unit_req after reset", int'(unit_req), 0);

    wr(2, 4'h1);

    // R2 R3 R4 auto-mode sweep over all load values
    for (int n = 0; n < 16; n++) begin
      wr(1, 4'(n));
      unit_done = 1'b1;
      wr(0, 4'h1);
      chk("R2 inactive on enable edge", int'(xfer_active), 0);
      run_units(40, u);
      unit_done = 1'b0;
      chk($sformatf("R3 units for load %0d", n), u, (n == 0) ? 16 : n);
      chk("R4 active low after last unit", int'(xfer_active), 0);
      rd(0, v); chk("R4 end flag set", (v >> 1) & 1, 1);
      rd(1, v); chk("R3 count exhausted", v, 0);
      wr(0, 4'h0);
      rd(0, v); chk("R5 read-then-write0 clears end", v, 0);
    end

    // R6 R5 blocked restart and clear protocol
    wr(1, 4'd2);
    unit_done = 1'b1;
    wr(0, 4'h1);
    run_units(10, u);
    unit_done = 1'b0;
    chk("R4 two units", u, 2);
    wr(0, 4'h1);
    blocked = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (xfer_active || unit_req) blocked++;
    end
    chk("R6 no transfer while end set", blocked, 0);
    rd(0, v); chk("R5 write0 without read ignored", (v >> 1) & 1, 1);
    wr(0, 4'h3);
    @(negedge clk);
    chk("R5 write1 leaves end set", int'(xfer_active), 0);
    wr(0, 4'h1);
    @(negedge clk);
    chk("R5 clear after read lets channel run", int'(xfer_active), 1);
    wr(0, 4'h0);

    // R7 disable mid-transfer
    wr(1, 4'd10);
    wr(0, 4'h1);
    @(negedge clk);
    chk("R2 active one edge after enable", int'(xfer_active), 1);
    unit_done = 1'b1;
    repeat (3) @(negedge clk);
    unit_done = 1'b0;
    wr(0, 4'h0);
    chk("R7 channel disable stops", int'(xfer_active), 0);
    rd(1, v); chk("R7 count after three units", v, 7);
    rd(0, v); chk("R7 no end flag on disable", (v >> 1) & 1, 0);
    unit_done = 1'b1;
    repeat (3) @(negedge clk);
    unit_done = 1'b0;
    rd(1, v); chk("R7 count frozen while disabled", v, 7);

    wr(0, 4'h1);
    @(negedge clk);
    wr(2, 4'h6);
    chk("R7 master disable stops", int'(xfer_active), 0);
    rd(2, v); chk("R5 write1 to error flags no effect", v, 0);
    rd(0, v); chk("R7 no end on master disable", (v >> 1) & 1, 0);
    wr(2, 4'h1);
    @(negedge clk);
    chk("R2 resumes with master enable", int'(xfer_active), 1);

    // R8 NMI and address error
    unit_done = 1'b1; nmi_evt = 1'b1;
    @(negedge clk);
    nmi_evt = 1'b0;
    chk("R8 nmi stops at once", int'(xfer_active), 0);
    repeat (3) @(negedge clk);
    unit_done = 1'b0;
    rd(1, v); chk("R8 no decrement on nmi", v, 7);
    wr(2, 4'h1);
    rd(2, v); chk("R8 nmi flag sticky", v, 3);
    rd(0, v); chk("R8 nmi does not set end", (v >> 1) & 1, 0);
    wr(2, 4'h1);
    @(negedge clk);
    chk("R8 resumes after nmi cleared", int'(xfer_active), 1);
    aerr_evt = 1'b1;
    @(negedge clk);
    aerr_evt = 1'b0;
    chk("R8 aerr stops", int'(xfer_active), 0);
    rd(2, v); chk("R8 aerr flag set", v, 5);
    wr(2, 4'h1);
    rd(2, v); chk("R8 aerr flag cleared", v, 1);
    wr(0, 4'h0);

    // R9 external request mode
    wr(1, 4'd3);
    wr(0, 4'h5);
    unit_done = 1'b1;
    blocked = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (unit_req || !xfer_active) blocked++;
    end
    per_req = 1'b1;
    @(negedge clk);
    per_req = 1'b0;
    @(negedge clk);
    if (unit_req) blocked++;
    chk("R9 ext mode waits, ignores per_req", blocked, 0);
    for (int k = 0; k < 3; k++) begin
      ext_req = 1'b1;
      @(negedge clk);
      ext_req = 1'b0;
      chk("R9 ext request raises unit_req", int'(unit_req), 1);
      @(negedge clk);
      chk("R9 single unit per request", int'(unit_req), 0);
    end
    unit_done = 1'b0;
    rd(0, v); chk("R4 end after ext units", (v >> 1) & 1, 1);
    wr(0, 4'h0);

    // R9 peripheral request mode
    wr(1, 4'd2);
    wr(0, 4'h9);
    unit_done = 1'b1;
    ext_req = 1'b1;
    @(negedge clk);
    ext_req = 1'b0;
    @(negedge clk);
    chk("R9 periph mode ignores ext_req", int'(unit_req), 0);
    per_req = 1'b1;
    @(negedge clk);
    per_req = 1'b0;
    chk("R9 per request raises unit_req", int'(unit_req), 1);
    @(negedge clk);
    unit_done = 1'b0;
    rd(1, v); chk("R3 periph count after one unit", v, 1);
    unit_done = 1'b1;
    per_req = 1'b1;
    @(negedge clk);
    per_req = 1'b0;
    @(negedge clk);
    unit_done = 1'b0;
    chk("R4 periph done", int'(xfer_active), 0);
    rd(0, v); chk("R4 end after periph units", (v >> 1) & 1, 1);

    finish_run();
  end
endmodule